// File: doc/BRIEF.md
# 16-bit Timer/Counter with Prescaler and Buffered Byte Access

This block is a 16-bit up-counter for a small microcontroller, reached over an 8-bit register bus. Its count source is either an internal instruction-cycle tick or rising edges on an external clock pin. The pin can be brought in through a two-flop synchronizer or taken straight from the pin. A divide-by-1/2/4/8 prescaler sits between the source and the counter, and an enable bit gates the source. When the count wraps from 0xFFFF to 0x0000, a sticky overflow flag is set. A trigger from a compare unit clears the count when this timer is that unit's selected time base.

Software sees four byte addresses: control (0), count low byte (1), count high byte (2) and status (3). In buffered 16-bit mode the high-byte address reaches a holding register instead of the live high byte. Reading the low byte captures the live high byte into that register, and writing the low byte loads the held high byte and the new low byte into the counter in one cycle. A 16-bit value read or written as two bytes is therefore always consistent. While the core is asleep, the internal and synchronized sources stop, but the direct pin path keeps counting.

Top module: `tmr16_unit`

## Requirements
- R1: With control bit 1 (source select) at 0 and the prescaler at 1:1, the count advances once every 4 clock cycles, so any window of 4k cycles after a count load adds exactly k.
- R2: Control bits 5:4 select the prescale ratio (0→1, 1→2, 2→4, 3→8). A write that loads the count clears the prescaler, so the counter then advances once per ratio source ticks.
- R3: With control bit 1 at 1, every rising edge of `ext_clk` is one source tick, both when control bit 2 is 0 (synchronized through two flops) and when it is 1 (direct).
- R4: While `core_sleep` is 1, the internal tick and the synchronized pin path produce no ticks, while the direct pin path (control bit 2 = 1) keeps counting.
- R5: While control bit 0 (enable) is 0, the count holds its value.
- R6: A wrap from 0xFFFF to 0x0000 by incrementing sets status bit 0 (address 3) and `ovf_flag`. The flag stays set until software writes status bit 0 with 0, and a wrap in the same cycle as that write leaves it set.
- R7: `cc_trig` clears the 16-bit count when `cc_tb_sel` is 1, and has no effect on the count when `cc_tb_sel` is 0.
- R8: With control bit 7 (buffered mode) at 1, reading address 1 copies the live high byte into the holding register. Address 2 reads and writes only the holding register, and writing address 1 loads {holding register, data} into the count at once.
- R9: With control bit 7 at 0, address 1 and address 2 read and write the live low and high count bytes directly.
- R10: A count load from the bus wins over a trigger clear and over an increment in the same cycle.
- R11: The control register reads back with bits 6 and 3 as 0, and every register reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 count low, 2 count high, 3 status |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, only needed for the buffered-mode capture |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| ext_clk | input | 1 | External count clock pin |
| core_sleep | input | 1 | Core asleep indication |
| cc_trig | input | 1 | Special-event trigger from the compare unit |
| cc_tb_sel | input | 1 | Compare unit uses this timer as its time base |
| ovf_flag | output | 1 | Sticky overflow interrupt flag |

## Verification
The internal source is driven with random start values and random prescale ratios over exact windows of 4·ratio·k cycles. A wrong divide ratio, a prescaler that survives a count load, or a missed wrap flag each change the final count or the flag. Pin pulse trains go through the synchronized and direct paths, with and without sleep and with several ratios, which separates the two paths and shows each edge counted once. Directed cases set a trigger with and without the select and against a simultaneous write, read low then high while the counter carries across a byte boundary, and load values just below the wrap.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BUS_W = 8;

    // Decoded control fields (bus bits 7, 5:4, 2, 1, 0)
    typedef struct packed {
        logic       rw16;    // buffered 16-bit access
        logic [1:0] ps;      // prescale select
        logic       nsync;   // 1 = direct pin path
        logic       cs;      // 1 = pin source
        logic       en;      // count enable
    } tctl_t;

    typedef enum logic [1:0] {
        A_CTL  = 2'd0,
        A_LO   = 2'd1,
        A_HI   = 2'd2,
        A_STAT = 2'd3
    } taddr_e;

    function automatic logic [BUS_W-1:0] ctl_to_bus(tctl_t c);
        return {c.rw16, 1'b0, c.ps, 1'b0, c.nsync, c.cs, c.en};
    endfunction

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_i,
    input  logic use_sync,
    input  logic sleep_i,
    output logic edge_o
);
    logic [STAGES-1:0] sf;
    logic              sf_prev;
    logic              raw_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sf[0] <= 1'b0;
                    else     sf[0] <= ext_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sf[i] <= 1'b0;
                    else     sf[i] <= sf[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sf_prev <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            sf_prev <= sf[STAGES-1];
            raw_q   <= ext_i;
        end
    end

    logic sync_edge, raw_edge;
    assign sync_edge = sf[STAGES-1] & ~sf_prev & ~sleep_i;
    assign raw_edge  = ext_i & ~raw_q;
    assign edge_o    = use_sync ? sync_edge : raw_edge;

endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_i,
    input  logic [PSW-1:0] sel_i,
    input  logic           clr_i,
    output logic           out_o
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] cnt;
    logic [PCW-1:0] lim;
    logic [PCW-1:0] ones;

    assign ones  = '1;
    assign lim   = ones >> (PCW - int'(sel_i));
    assign out_o = tick_i & (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt <= '0;
        else if (tick_i)   cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_i,
    input  logic          trig_clr_i,
    input  logic          rw16_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic          rd_lo_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          st_wr_i,
    input  logic          st_bit_i,
    output logic          load_o,
    output logic [2*DW-1:0] cnt_o,
    output logic [DW-1:0] hbuf_o,
    output logic          ovf_o
);
    localparam int CW = 2 * DW;

    logic [CW-1:0] cnt;
    logic [DW-1:0] hbuf;
    logic          ovf;
    logic          wrap;

    assign load_o = wr_lo_i | (wr_hi_i & ~rw16_i);
    assign wrap   = inc_i & ~load_o & ~trig_clr_i & (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_o) begin
            if (rw16_i) begin
                cnt <= {hbuf, wdata_i};
            end else begin
                if (wr_lo_i) cnt[DW-1:0]  <= wdata_i;
                if (wr_hi_i) cnt[CW-1:DW] <= wdata_i;
            end
        end else if (trig_clr_i) begin
            cnt <= '0;
        end else if (inc_i) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    hbuf <= '0;
        else if (rw16_i && wr_hi_i) hbuf <= wdata_i;
        else if (rw16_i && rd_lo_i) hbuf <= cnt[CW-1:DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else begin
            if (st_wr_i) ovf <= st_bit_i;
            if (wrap)    ovf <= 1'b1;
        end
    end

    assign cnt_o  = cnt;
    assign hbuf_o = hbuf;
    assign ovf_o  = ovf;

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
    import tmr16_pkg::*;
#(
    parameter int IDIV        = 4,
    parameter int PSW         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ext_clk,
    input  logic             core_sleep,
    input  logic             cc_trig,
    input  logic             cc_tb_sel,
    output logic             ovf_flag
);
    localparam int PHW = (IDIV > 1) ? $clog2(IDIV) : 1;
    localparam int CW  = 2 * BUS_W;

    tctl_t            ctl;
    logic [PHW-1:0]   phase;
    logic             int_tick, ext_tick, src_tick, inc;
    logic             wr_ctl, wr_lo, wr_hi, wr_st, rd_lo;
    logic             load, trig_clr;
    logic [CW-1:0]    cnt;
    logic [BUS_W-1:0] hbuf;

    assign wr_ctl = bus_wr && (taddr_e'(bus_addr) == A_CTL);
    assign wr_lo  = bus_wr && (taddr_e'(bus_addr) == A_LO);
    assign wr_hi  = bus_wr && (taddr_e'(bus_addr) == A_HI);
    assign wr_st  = bus_wr && (taddr_e'(bus_addr) == A_STAT);
    assign rd_lo  = bus_rd && (taddr_e'(bus_addr) == A_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl.rw16  <= bus_wdata[7];
            ctl.ps    <= bus_wdata[5:4];
            ctl.nsync <= bus_wdata[2];
            ctl.cs    <= bus_wdata[1];
            ctl.en    <= bus_wdata[0];
        end
    end

    // Instruction-cycle phase
    always_ff @(posedge clk) begin
        if (rst)                           phase <= '0;
        else if (phase == PHW'(IDIV - 1))  phase <= '0;
        else                               phase <= phase + 1'b1;
    end
    assign int_tick = (phase == PHW'(IDIV - 1)) & ~core_sleep;

    tmr16_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .ext_i    (ext_clk),
        .use_sync (~ctl.nsync),
        .sleep_i  (core_sleep),
        .edge_o   (ext_tick)
    );

    assign src_tick = (ctl.cs ? ext_tick : int_tick) & ctl.en;

    tmr16_presc #(.PSW(PSW)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .tick_i (src_tick),
        .sel_i  (ctl.ps),
        .clr_i  (load),
        .out_o  (inc)
    );

    assign trig_clr = cc_trig & cc_tb_sel;

    tmr16_core #(.DW(BUS_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .inc_i      (inc),
        .trig_clr_i (trig_clr),
        .rw16_i     (ctl.rw16),
        .wr_lo_i    (wr_lo),
        .wr_hi_i    (wr_hi),
        .rd_lo_i    (rd_lo),
        .wdata_i    (bus_wdata),
        .st_wr_i    (wr_st),
        .st_bit_i   (bus_wdata[0]),
        .load_o     (load),
        .cnt_o      (cnt),
        .hbuf_o     (hbuf),
        .ovf_o      (ovf_flag)
    );

    always_comb begin
        case (taddr_e'(bus_addr))
            A_CTL:   bus_rdata = ctl_to_bus(ctl);
            A_LO:    bus_rdata = cnt[BUS_W-1:0];
            A_HI:    bus_rdata = ctl.rw16 ? hbuf : cnt[CW-1:BUS_W];
            default: bus_rdata = {{(BUS_W-1){1'b0}}, ovf_flag};
        endcase
    end

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [2*DW-1:0] cnt,
    input logic [DW-1:0]   hbuf,
    input logic            ovf,
    input logic            en,
    input logic            rw16,
    input logic            load,
    input logic            trig,
    input logic            tb_sel,
    input logic            st_wr,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [1:0]      bus_addr,
    input logic [DW-1:0]   bus_wdata
);
    localparam int CW = 2 * DW;

    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !load && !(trig && tb_sel)) |=> (cnt == $past(cnt)));

    a_r1_step_at_most_one: assert property (@(posedge clk) disable iff (rst)
        (!load && !(trig && tb_sel)) |=>
        ((cnt == $past(cnt)) || (cnt == CW'($past(cnt) + 1'b1))));

    a_r7_trig_clears: assert property (@(posedge clk) disable iff (rst)
        (trig && tb_sel && !load) |=> (cnt == '0));

    a_r7_trig_ignored: assert property (@(posedge clk) disable iff (rst)
        (trig && !tb_sel && !en && !load) |=> (cnt == $past(cnt)));

    a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '1) && !load && !(trig && tb_sel)) |=> ((cnt != '0) || ovf));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !st_wr) |=> ovf);

    a_r8_capture_high: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 2'd1 && rw16) |=>
        (hbuf == $past(cnt[CW-1:DW])));

    a_r10_load_low_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1 && !rw16) |=> (cnt[DW-1:0] == $past(bus_wdata)));

endmodule

bind tmr16_unit tmr16_chk #(.DW(8)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .hbuf      (hbuf),
    .ovf       (ovf_flag),
    .en        (ctl.en),
    .rw16      (ctl.rw16),
    .load      (load),
    .trig      (cc_trig),
    .tb_sel    (cc_tb_sel),
    .st_wr     (wr_st),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_tmr16_unit.sv
`timescale 1ns/1ps
module sim_tmr16_unit;
    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] bus_addr = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 0, core_sleep = 0, cc_trig = 0, cc_tb_sel = 0;
    logic       ovf_flag;

    int tests = 0, fails = 0;

    tmr16_unit u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .core_sleep(core_sleep), .cc_trig(cc_trig),
        .cc_tb_sel(cc_tb_sel), .ovf_flag(ovf_flag)
    );

    always #4 clk = ~clk;

    localparam logic [7:0] EN = 8'h01, CS = 8'h02, NSY = 8'h04, RW = 8'h80;

    function automatic logic [7:0] ps_bits(int ps);
        return 8'(ps << 4);
    endfunction
    function automatic logic [15:0] exp_count(logic [15:0] v, int k);
        return 16'(int'(v) + k);
    endfunction
    function automatic logic exp_wrap(logic [15:0] v, int k);
        return (int'(v) + k) > 65535;
    endfunction

    task automatic check(string req, int got, int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // caller is at a negedge; returns at the following negedge
    task automatic bwrite(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask
    task automatic bread(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 0;
    endtask
    task automatic peek16(output logic [15:0] v);
        bus_addr = 2'd1; #1 v[7:0] = bus_rdata;
        bus_addr = 2'd2; #1 v[15:8] = bus_rdata;
    endtask
    task automatic peek(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask
    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask
    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1; repeat (3) @(negedge clk);
            ext_clk = 0; repeat (3) @(negedge clk);
        end
    endtask
    task automatic load16(logic [15:0] v);
        bwrite(2'd2, v[15:8]);
        bwrite(2'd1, v[7:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R11 reset state
        peek(2'd0, d); check("R11 reset ctl", d, 0);
        peek16(v);     check("R11 reset count", v, 0);
        peek(2'd3, d); check("R11 reset flag", d, 0);
        check("R11 reset ovf_flag", ovf_flag, 0);
        @(negedge clk);

        // R11 control readback mask
        bwrite(2'd0, 8'hFF);
        peek(2'd0, d); check("R11 ctl mask", d, 8'hB7);
        @(negedge clk);
        bwrite(2'd0, 8'h00);

        // R1 R2 R6 random internal counting
        for (int it = 0; it < 24; it++) begin
            int ps = $urandom % 4;
            int k  = 1 + $urandom % 20;
            logic [15:0] st = (it % 2) ? 16'($urandom) : 16'(16'hFFFF - $urandom % 12);
            bwrite(2'd0, ps_bits(ps));
            bwrite(2'd2, st[15:8]);
            bwrite(2'd3, 8'h00);
            bwrite(2'd0, ps_bits(ps) | EN);
            bwrite(2'd1, st[7:0]);
            wait_cyc(4 * (1 << ps) * k);
            peek16(v); check("R1/R2 internal count", v, exp_count(st, k));
            peek(2'd3, d); check("R6 wrap flag", d, exp_wrap(st, k));
            @(negedge clk);
        end

        // R3 synchronized pin path
        bwrite(2'd0, CS | EN);
        load16(16'h0000);
        pulses(5); wait_cyc(8);
        peek16(v); check("R3 sync edges", v, 5);
        @(negedge clk);
        // R3 direct pin path
        bwrite(2'd0, NSY | CS | EN);
        load16(16'h0000);
        pulses(7); wait_cyc(8);
        peek16(v); check("R3 direct edges", v, 7);
        @(negedge clk);
        // R2 prescaler on pin source
        bwrite(2'd0, ps_bits(1) | CS | EN);
        load16(16'h0000);
        pulses(6); wait_cyc(8);
        peek16(v); check("R2 pin div2", v, 3);
        @(negedge clk);
        bwrite(2'd0, ps_bits(3) | NSY | CS | EN);
        load16(16'h0000);
        pulses(17); wait_cyc(8);
        peek16(v); check("R2 pin div8", v, 2);
        @(negedge clk);

        // R4 sleep
        core_sleep = 1;
        bwrite(2'd0, NSY | CS | EN);
        load16(16'h0000);
        pulses(4); wait_cyc(8);
        peek16(v); check("R4 direct path in sleep", v, 4);
        @(negedge clk);
        bwrite(2'd0, CS | EN);
        load16(16'h0000);
        pulses(4); wait_cyc(8);
        peek16(v); check("R4 sync path in sleep", v, 0);
        @(negedge clk);
        bwrite(2'd0, EN);
        load16(16'h0000);
        wait_cyc(40);
        peek16(v); check("R4 internal in sleep", v, 0);
        @(negedge clk);
        core_sleep = 0;

        // R5 enable off
        bwrite(2'd0, 8'h00);
        load16(16'h00AA);
        wait_cyc(40);
        peek16(v); check("R5 hold internal", v, 16'h00AA);
        @(negedge clk);
        bwrite(2'd0, NSY | CS);
        pulses(3); wait_cyc(4);
        peek16(v); check("R5 hold pin", v, 16'h00AA);
        @(negedge clk);

        // R6 directed wrap, sticky, clear
        bwrite(2'd0, 8'h00);
        load16(16'hFFFE);
        bwrite(2'd3, 8'h00);
        bwrite(2'd0, EN);
        wait_cyc(20);
        peek16(v); check("R6 wrap count", v, 16'h0003);
        check("R6 flag set", ovf_flag, 1);
        @(negedge clk);
        bwrite(2'd0, 8'h00);
        wait_cyc(10);
        check("R6 flag sticky", ovf_flag, 1);
        bwrite(2'd3, 8'h00);
        check("R6 flag cleared", ovf_flag, 0);

        // R7 trigger
        load16(16'h1234);
        cc_trig = 1; cc_tb_sel = 0;
        @(posedge clk); @(negedge clk); cc_trig = 0;
        peek16(v); check("R7 trigger unselected", v, 16'h1234);
        @(negedge clk);
        cc_trig = 1; cc_tb_sel = 1;
        @(posedge clk); @(negedge clk); cc_trig = 0;
        peek16(v); check("R7 trigger clears", v, 0);
        @(negedge clk);

        // R10 load beats trigger
        load16(16'h3400);
        cc_trig = 1; cc_tb_sel = 1;
        bwrite(2'd1, 8'h55);
        cc_trig = 0; cc_tb_sel = 0;
        peek16(v); check("R10 write over trigger", v, 16'h3455);
        @(negedge clk);

        // R9 direct high write
        bwrite(2'd2, 8'h7E);
        peek16(v); check("R9 direct high", v, 16'h7E55);
        @(negedge clk);

        // R8 buffered mode
        bwrite(2'd0, RW);
        bwrite(2'd2, 8'hAB);
        peek16(v); check("R8 high write buffered only", v[7:0], 8'h55);
        @(negedge clk);
        bwrite(2'd1, 8'hCD);
        bwrite(2'd0, 8'h00);
        peek16(v); check("R8 atomic load", v, 16'hABCD);
        @(negedge clk);
        bwrite(2'd0, RW | EN);
        bwrite(2'd2, 8'h01);
        bwrite(2'd1, 8'hFF);
        bread(2'd1, d); check("R8 low read", d, 8'hFF);
        wait_cyc(40);
        peek(2'd2, d); check("R8 captured high", d, 8'h01);
        @(negedge clk);
        bwrite(2'd0, 8'h00);
        peek(2'd2, d); check("R9 live high", d, 8'h02);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule